// File: doc/BRIEF.md
# Seven-word carry-save population counter

The block returns how many bits are set across a group of seven 64-bit words. Instead of counting each word on its own and adding seven small results, it first runs all 64 bit lanes of the group through a small tree of bitwise full adders. This turns seven words into three weighted words: a ones word, a twos word and a fours word. Each weighted word is then reduced to per-byte counts with masked shift-and-add steps inside the word. The byte counts are summed and combined with their weights to give a total between 0 and 448.

A group is offered with a one-cycle valid strobe. A new group can be accepted on every cycle. The result appears on the output three cycles later with its own valid flag. The count stays on the output until the next result replaces it.

Top module: `popc7_top`

## Requirements
- R1: When out_valid is high, out_count (9-bit unsigned) equals the number of set bits across all seven words of the matching input group, in the range 0 to 448.
- R2: A group sampled with in_valid high at a rising clock edge produces out_valid high, with its count, exactly three rising edges later. Every accepted group produces exactly one result.
- R3: Groups may arrive on consecutive cycles. Each produces its own result, in arrival order, on consecutive cycles.
- R4: An all-zero group gives 0. An all-ones group gives 448.
- R5: When no result is being presented, out_count keeps the value of the most recent result.
- R6: While rst_n is low, out_valid is 0 and out_count is 0. Any group still in flight when reset is asserted is discarded.
- R7: Input words presented with in_valid low produce no result, and they leave out_count unchanged.
- R8: Every word position and every bit position carries the same weight. A single set bit anywhere in the group gives 1, and a fully set single word gives 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released in step with the clock. |
| in_valid | input | 1 | High when in_words holds a group to count |
| in_words | input | 448 | Seven 64-bit words. Word k occupies bits [64k+63:64k]. |
| out_valid | output | 1 | High for one cycle per result |
| out_count | output | 9 | Number of set bits in the group |

## Verification
The all-zero and all-ones groups fix the two ends of the range; all-ones also catches a lost carry into the fours word. Single set bits, moved across every word and across the low, high and middle bit positions, check that each of the seven adder inputs and each lane is weighted 1. A single fully set word checks that the merge weights give 64 rather than a doubled or halved value. Random groups, sent back to back and with gaps, check the whole tree under mixed carries and check that results keep their order. Idle cycles carrying non-zero data, a three-cycle latency probe and a reset in mid-flight check that the output is held, timed correctly and cleared on reset.

// File: rtl/popc7_pkg.sv
package popc7_pkg;
  parameter int WORD_W = 64;
  parameter int N_IN   = 7;
  localparam int N_WT  = 3;
  localparam int CNT_W = $clog2(N_IN * WORD_W + 1);
  localparam int PC_W  = $clog2(WORD_W + 1);

  // Mask selecting the low fw bits of every 2*fw-bit field.
  function automatic logic [WORD_W-1:0] field_mask(input int fw);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) begin
      m[b] = ((b % (2 * fw)) < fw);
    end
    return m;
  endfunction
endpackage

// File: rtl/csa_fa.sv
module csa_fa #(
  parameter int W = popc7_pkg::WORD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] cin,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] t;

  always_comb begin
    t     = a ^ b;
    sum   = t ^ cin;
    carry = (a & b) | (t & cin);
  end
endmodule

// File: rtl/csa_compress7.sv
module csa_compress7 #(
  parameter int W = popc7_pkg::WORD_W,
  parameter int N = popc7_pkg::N_IN
) (
  input  logic [N*W-1:0] words,
  output logic [W-1:0]   s0,
  output logic [W-1:0]   s1,
  output logic [W-1:0]   s2
);
  logic [W-1:0] x0, x1, y0, y1, z1;

  csa_fa #(.W(W)) fa_x (
    .a(words[0*W +: W]), .b(words[1*W +: W]), .cin(words[2*W +: W]),
    .sum(x0), .carry(x1));
  csa_fa #(.W(W)) fa_y (
    .a(words[3*W +: W]), .b(words[4*W +: W]), .cin(words[5*W +: W]),
    .sum(y0), .carry(y1));
  csa_fa #(.W(W)) fa_z (
    .a(x0), .b(y0), .cin(words[6*W +: W]),
    .sum(s0), .carry(z1));
  csa_fa #(.W(W)) fa_s (
    .a(x1), .b(y1), .cin(z1),
    .sum(s1), .carry(s2));

  // R1: in every lane the weighted outputs equal the number of set inputs
  always_comb begin
    logic [N-1:0] lane;
    for (int b = 0; b < W; b++) begin
      for (int k = 0; k < N; k++) lane[k] = words[k*W + b];
      a_r1_lane_weight: assert ($countones(lane) ==
        int'(s0[b]) + 2 * int'(s1[b]) + 4 * int'(s2[b]))
        else $error("lane %0d weight mismatch", b);
    end
  end
endmodule

// File: rtl/swar_reduce.sv
module swar_reduce #(
  parameter int W = popc7_pkg::WORD_W
) (
  input  logic [W-1:0] v,
  output logic [W-1:0] byte_cnt
);
  localparam int N_ST = 3;
  localparam int N_BY = W / 8;

  logic [W-1:0] st [N_ST+1];

  assign st[0] = v;

  for (genvar k = 0; k < N_ST; k++) begin : g_st
    localparam int SH = 1 << k;
    localparam logic [W-1:0] M = popc7_pkg::field_mask(SH);
    if (k < 2) begin : g_pre
      assign st[k+1] = (st[k] & M) + ((st[k] >> SH) & M);
    end else begin : g_post
      assign st[k+1] = (st[k] + (st[k] >> SH)) & M;
    end
  end

  assign byte_cnt = st[N_ST];

  // R1: no byte field can exceed eight set bits
  always_comb begin
    for (int j = 0; j < N_BY; j++) begin
      a_r1_byte_range: assert (byte_cnt[8*j +: 8] <= 8)
        else $error("byte %0d field overflow", j);
    end
  end
endmodule

// File: rtl/byte_sum.sv
module byte_sum #(
  parameter int W    = popc7_pkg::WORD_W,
  parameter int PC_W = popc7_pkg::PC_W
) (
  input  logic [W-1:0]    byte_cnt,
  output logic [PC_W-1:0] pc
);
  localparam int N_BY = W / 8;

  always_comb begin
    pc = '0;
    for (int j = 0; j < N_BY; j++) begin
      pc = pc + PC_W'(byte_cnt[8*j +: 8]);
    end
  end
endmodule

// File: rtl/popc7_top.sv
module popc7_top
  import popc7_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N_IN*WORD_W-1:0]  in_words,
  output logic                    out_valid,
  output logic [CNT_W-1:0]        out_count
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  // stage 1: carry-save compression
  logic [WORD_W-1:0] wt_nx [N_WT];
  logic [WORD_W-1:0] wt_q  [N_WT];
  logic              v1_q;

  csa_compress7 #(.W(WORD_W), .N(N_IN)) u_cmp (
    .words(in_words), .s0(wt_nx[0]), .s1(wt_nx[1]), .s2(wt_nx[2]));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      v1_q <= 1'b0;
      for (int k = 0; k < N_WT; k++) wt_q[k] <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < N_WT; k++) wt_q[k] <= wt_nx[k];
      end
    end
  end

  // stage 2: in-word byte counts for each weighted word
  logic [WORD_W-1:0] by_nx [N_WT];
  logic [WORD_W-1:0] by_q  [N_WT];
  logic              v2_q;

  for (genvar k = 0; k < N_WT; k++) begin : g_red
    swar_reduce #(.W(WORD_W)) u_red (.v(wt_q[k]), .byte_cnt(by_nx[k]));
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      v2_q <= 1'b0;
      for (int k = 0; k < N_WT; k++) by_q[k] <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        for (int k = 0; k < N_WT; k++) by_q[k] <= by_nx[k];
      end
    end
  end

  // stage 3: sum bytes and merge with weights 1, 2, 4
  logic [PC_W-1:0]  pc   [N_WT];
  logic [CNT_W-1:0] count_nx;

  for (genvar k = 0; k < N_WT; k++) begin : g_sum
    byte_sum #(.W(WORD_W), .PC_W(PC_W)) u_sum (.byte_cnt(by_q[k]), .pc(pc[k]));
  end

  always_comb begin
    count_nx = '0;
    for (int k = 0; k < N_WT; k++) begin
      count_nx = count_nx + (CNT_W'(pc[k]) << k);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_valid <= 1'b0;
      out_count <= '0;
    end else begin
      out_valid <= v2_q;
      if (v2_q) out_count <= count_nx;
    end
  end

  // R2: each pipeline stage hands its valid on one cycle later
  a_r2_stage1: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> v1_q);
  a_r2_stage2: assert property (@(posedge clk) disable iff (!rst_s_n)
    v1_q |=> v2_q);
  a_r2_stage3: assert property (@(posedge clk) disable iff (!rst_s_n)
    v2_q |=> out_valid);
  // R7: an idle input yields no result
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> !v1_q);
  // R5: the count holds while no result is loaded
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !v2_q |=> $stable(out_count));
  // R1: a result never exceeds the group size
  a_r1_max: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> (int'(out_count) <= N_IN * WORD_W));
endmodule

// File: tb/popc7_top_tb_top.sv
`timescale 1ns/1ps
module popc7_top_tb_top;
  localparam int W  = 64;
  localparam int N  = 7;
  localparam int TW = N * W;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [TW-1:0] in_words;
  logic          out_valid;
  logic [8:0]    out_count;

  int    n_chk;
  int    n_fail;
  int    last_res;
  bit    done;
  int    exp_q[$];
  string tag_q[$];

  popc7_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_count(out_count));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_count(input logic [TW-1:0] w);
    int c = 0;
    for (int b = 0; b < TW; b++) if (w[b]) c++;
    return c;
  endfunction

  function automatic logic [TW-1:0] rand_group();
    logic [TW-1:0] w;
    for (int k = 0; k < N; k++) w[k*W +: W] = {$urandom, $urandom};
    return w;
  endfunction

  task automatic send(input logic [TW-1:0] w, input string tag);
    in_words = w;
    in_valid = 1'b1;
    exp_q.push_back(ref_count(w));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n, input logic [TW-1:0] w);
    in_valid = 1'b0;
    in_words = w;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected result", int'(out_count), -1);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(out_count) == e, t, int'(out_count), e);
        last_res = e;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] w;
    n_chk = 0; n_fail = 0; last_res = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_words = '0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R6 valid in reset", int'(out_valid), 0);
    chk(out_count == 9'd0, "R6 count in reset", int'(out_count), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R6 valid after release", int'(out_valid), 0);

    // R4 range ends
    send('0, "R4 all zero");
    send('1, "R4 all ones");
    idle(5, '0);

    // R2 latency probe: result visible after the third rising edge
    send(rand_group(), "R2 latency value");
    chk(out_valid == 1'b0, "R2 early edge one", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 early edge two", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 third edge", int'(out_valid), 1);
    idle(4, '0);

    // R8 single bits in every word, at low, high and middle positions
    for (int k = 0; k < N; k++) begin
      w = '0; w[k*W] = 1'b1;          send(w, "R8 single low bit");
      w = '0; w[k*W + W-1] = 1'b1;    send(w, "R8 single high bit");
      w = '0; w[k*W + 17 + k] = 1'b1; send(w, "R8 single mid bit");
      w = '0; w[k*W +: W] = '1;       send(w, "R8 full word");
    end
    idle(4, '0);

    // R1 alternating patterns
    w = '0;
    for (int k = 0; k < N; k++) w[k*W +: W] = {16{4'hA}};
    send(w, "R1 alternating");
    send(~w, "R1 alternating inverse");

    // R3 random back to back
    for (int i = 0; i < 200; i++) send(rand_group(), "R3 back to back");
    // R1 random with gaps
    for (int i = 0; i < 60; i++) begin
      send(rand_group(), "R1 random gapped");
      idle(i % 3, rand_group());
    end
    idle(5, '0);

    // R5 / R7 idle with live data on the inputs
    idle(8, '1);
    chk(out_valid == 1'b0, "R7 no result from idle data", int'(out_valid), 0);
    chk(int'(out_count) == last_res, "R5 count held", int'(out_count), last_res);
    chk(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 0);

    // R6 reset while a group is in flight
    send('1, "R6 discarded");
    rst_n = 1'b0;
    exp_q.delete();
    tag_q.delete();
    #1;
    chk(out_valid == 1'b0, "R6 valid after mid reset", int'(out_valid), 0);
    chk(out_count == 9'd0, "R6 count after mid reset", int'(out_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0, "R6 in-flight group dropped", int'(out_valid), 0);
    chk(out_count == 9'd0, "R6 count stays clear", int'(out_count), 0);

    send(rand_group(), "R1 after reset");
    idle(5, '0);
    chk(exp_q.size() == 0, "R2 final drain", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule